// File: doc/BRIEF.md
# Security-banked binary-point register slice

This block is the per-CPU register slice of an interrupt controller's CPU interface. It holds the priority mask, the binary-point setting with its aliased copy, and a small file of active-priority words. A simple bus port drives it with a write strobe, a read strobe, a byte offset, 32-bit data and a flag that marks an access as non-secure. The block decodes the offset and applies the rules on which copy of the binary point an access reaches.

Two elaboration parameters shape the behaviour. `SEC_EXT` says whether the interface supports two security states. `ARCH_REV` gives the architecture revision.

With two security states, the binary point is banked. Secure accesses reach the primary copy. Non-secure accesses at the primary offset reach the aliased copy, which never holds a value below 1. The alias offset is then readable and writable only by secure accesses. With one security state and revision 2 or later, the alias offset acts as a second, clamped view of the binary point. Writes through either offset keep both copies equal: a write at the primary offset also copies its value into the aliased copy. Below revision 2 the alias offset does nothing. Acknowledge, end-of-interrupt, running-priority and pending offsets are handled elsewhere. Here they read as zero and ignore writes.

Top module: `cpuif_regbank`

## Requirements
- R1: After reset, every offset reads 0, with two exceptions when `SEC_EXT`=1: a secure read of 0x1C and a non-secure read of 0x08 both return 1. `rdata` is 0.
- R2: A write to offset 0x04 stores `wdata[7:0]` as the priority mask. Reading 0x04 returns it with bits 31..8 zero, whatever the security flag.
- R3: A write to offset 0x08 stores `wdata[2:0]` in the primary binary point, unclamped. This holds for secure writes when `SEC_EXT`=1, and for any write when `SEC_EXT`=0. A read of 0x08 by such an access returns the primary copy with bits 31..3 zero.
- R4: When `SEC_EXT`=1, a non-secure access to 0x08 reaches the aliased copy. A non-secure write stores `wdata[2:0]`, or 1 if that field is 0. A non-secure read returns the aliased copy, which is therefore never 0.
- R5: A read of offset 0x1C returns 0 in two cases: when `SEC_EXT`=0, and when the access is non-secure.
- R6: When `SEC_EXT`=1, a secure write to 0x1C stores `wdata[2:0]` in the aliased copy, or 1 if that field is 0. A secure read of 0x1C returns the aliased copy. A non-secure write to 0x1C leaves both copies unchanged.
- R7: When `SEC_EXT`=0 and `ARCH_REV`>=2, a write to 0x1C stores the clamped field (0 becomes 1) in the primary copy, which then reads back at 0x08. When `SEC_EXT`=0 and `ARCH_REV`<2, writes to 0x1C change nothing.
- R8: Offsets 0xD0, 0xD4, 0xD8 and 0xDC hold four independent 32-bit active-priority words, indexed by (offset-0xD0)/4. They are not banked.
- R9: Every other offset reads 0, and writes to it change no readable register. Offset bits 1..0 are ignored.
- R10: `rdata` takes the addressed value on the clock edge where `rd_en` is sampled high, and holds it while `rd_en` is low. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wdata | input | DATA_W (32) | Write data |
| nonsec | input | 1 | High for a non-secure access |
| rdata | output | DATA_W (32) | Registered read data |

## Verification
The bench builds four copies side by side, one for each pairing of `SEC_EXT` in {0,1} and `ARCH_REV` in {1,2}, and drives them all with the same bus traffic. This brings every banking, aliasing and read-as-zero case within one run. It sweeps all eight binary-point field values, including 0, through both offsets from both security states. It reads all 64 word offsets under both flags, so the clamp, the ignored alias writes and the unmapped offsets are each seen in every configuration.

// File: rtl/cpuif_pkg.sv
// Package: shared constants, register kinds and the non-secure clamp
// for the CPU-interface register slice. Assumes 32-bit word addressing.
package cpuif_pkg;
    localparam int BPT_W      = 3;
    localparam int WD_PMASK   = 1;   // byte 0x04
    localparam int WD_BPT     = 2;   // byte 0x08
    localparam int WD_ALIAS   = 7;   // byte 0x1C
    localparam int WD_APR0    = 52;  // byte 0xD0

    localparam logic [BPT_W-1:0] BPT_MIN_SEC = 3'd0;
    localparam logic [BPT_W-1:0] BPT_MIN_NS  = BPT_MIN_SEC + 3'd1;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PMASK,
        RK_BPT,
        RK_ALIAS,
        RK_APR
    } reg_kind_e;

    // Raise a binary-point field to the non-secure floor.
    function automatic logic [BPT_W-1:0] bpt_floor(input logic [BPT_W-1:0] v);
        return (v < BPT_MIN_NS) ? BPT_MIN_NS : v;
    endfunction
endpackage

// File: rtl/cpuif_decode.sv
// Module: cpuif_decode
// Maps a byte offset onto a register kind and an active-priority index.
// Assumes offset bits [1:0] are don't-care. Purely combinational.
module cpuif_decode
    import cpuif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_APR  = 4,
    localparam int WORD_W = ADDR_W - 2,
    localparam int IDX_W  = (N_APR > 1) ? $clog2(N_APR) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  apr_idx
);
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] apr_off;

    assign word    = addr[ADDR_W-1:2];
    assign apr_off = word - WORD_W'(WD_APR0);

    // Classify the word offset.
    always_comb begin
        kind    = RK_NONE;
        apr_idx = '0;
        if (word == WORD_W'(WD_PMASK)) begin
            kind = RK_PMASK;
        end else if (word == WORD_W'(WD_BPT)) begin
            kind = RK_BPT;
        end else if (word == WORD_W'(WD_ALIAS)) begin
            kind = RK_ALIAS;
        end else if (word >= WORD_W'(WD_APR0) &&
                     {1'b0, word} < (WORD_W+1)'(WD_APR0 + N_APR)) begin
            kind    = RK_APR;
            apr_idx = IDX_W'(apr_off);
        end
    end
endmodule

// File: rtl/cpuif_bpt_bank.sv
// Module: cpuif_bpt_bank
// Holds the primary and aliased binary-point copies and applies the
// banking, mirroring, clamping and read-as-zero rules. Assumes wr_bpt
// and wr_alias are never high together (they come from one decoder).
module cpuif_bpt_bank
    import cpuif_pkg::*;
#(
    parameter bit          SEC_EXT  = 1'b1,
    parameter int unsigned ARCH_REV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_bpt,
    input  logic             wr_alias,
    input  logic             nonsec,
    input  logic [BPT_W-1:0] wval,
    output logic [BPT_W-1:0] bpt_rd,
    output logic [BPT_W-1:0] alias_rd
);
    localparam bit REV2 = (ARCH_REV >= 2);

    logic [BPT_W-1:0] prim_q;
    logic [BPT_W-1:0] alias_q;
    logic [BPT_W-1:0] wfloor;

    assign wfloor = bpt_floor(wval);

    generate
        if (SEC_EXT) begin : g_banked
            // Banked update: the security flag selects the copy.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prim_q  <= BPT_MIN_SEC;
                    alias_q <= BPT_MIN_NS;
                end else begin
                    if (wr_bpt && !nonsec)  prim_q  <= wval;
                    if (wr_bpt && nonsec)   alias_q <= wfloor;
                    if (wr_alias && !nonsec) alias_q <= wfloor;
                end
            end
            assign bpt_rd   = nonsec ? alias_q : prim_q;
            assign alias_rd = nonsec ? '0 : alias_q;
        end else begin : g_flat
            // Single-state update: both offsets keep the copies mirrored.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prim_q  <= BPT_MIN_SEC;
                    alias_q <= BPT_MIN_NS;
                end else if (wr_bpt) begin
                    prim_q <= wval;
                    if (REV2) alias_q <= wval;
                end else if (wr_alias && REV2) begin
                    prim_q  <= wfloor;
                    alias_q <= wfloor;
                end
            end
            assign bpt_rd   = prim_q;
            assign alias_rd = '0;
        end
    endgenerate

    logic unused_alias;
    assign unused_alias = ^alias_q;
endmodule

// File: rtl/cpuif_apr_file.sv
// Module: cpuif_apr_file
// A row of N_APR full-width active-priority words with one-hot write
// selects. Assumes at most one select is high per cycle.
module cpuif_apr_file #(
    parameter int DATA_W = 32,
    parameter int N_APR  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_APR-1:0]              wr_sel,
    input  logic [DATA_W-1:0]             wdata,
    output logic [N_APR-1:0][DATA_W-1:0]  words
);
    generate
        for (genvar k = 0; k < N_APR; k++) begin : g_word
            // Store word k on its select.
            always_ff @(posedge clk) begin
                if (!rst_n)         words[k] <= '0;
                else if (wr_sel[k]) words[k] <= wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/cpuif_regbank.sv
// Module: cpuif_regbank (top)
// Per-CPU register slice of an interrupt CPU interface: priority mask,
// banked binary point with alias, active-priority words, registered
// read data. Assumes DATA_W >= PM_W and single-cycle strobes.
module cpuif_regbank
    import cpuif_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter int          N_APR    = 4,
    parameter int          PM_W     = 8,
    parameter bit          SEC_EXT  = 1'b1,
    parameter int unsigned ARCH_REV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              nonsec,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = (N_APR > 1) ? $clog2(N_APR) : 1;

    reg_kind_e                  kind;
    logic [IDX_W-1:0]           apr_idx;
    logic [PM_W-1:0]            pmask_q;
    logic [BPT_W-1:0]           bpt_rd;
    logic [BPT_W-1:0]           alias_rd;
    logic [N_APR-1:0]           apr_sel;
    logic [N_APR-1:0][DATA_W-1:0] apr_words;
    logic [DATA_W-1:0]          rd_mux;

    cpuif_decode #(.ADDR_W(ADDR_W), .N_APR(N_APR)) u_dec (
        .addr    (addr),
        .kind    (kind),
        .apr_idx (apr_idx)
    );

    cpuif_bpt_bank #(.SEC_EXT(SEC_EXT), .ARCH_REV(ARCH_REV)) u_bpt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_bpt   (wr_en && kind == RK_BPT),
        .wr_alias (wr_en && kind == RK_ALIAS),
        .nonsec   (nonsec),
        .wval     (wdata[BPT_W-1:0]),
        .bpt_rd   (bpt_rd),
        .alias_rd (alias_rd)
    );

    // One-hot write select for the active-priority words.
    always_comb begin
        apr_sel = '0;
        if (wr_en && kind == RK_APR) apr_sel[apr_idx] = 1'b1;
    end

    cpuif_apr_file #(.DATA_W(DATA_W), .N_APR(N_APR)) u_apr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (apr_sel),
        .wdata  (wdata),
        .words  (apr_words)
    );

    // Priority mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pmask_q <= '0;
        else if (wr_en && kind == RK_PMASK) pmask_q <= wdata[PM_W-1:0];
    end

    // Read selection; unmapped kinds return zero.
    always_comb begin
        case (kind)
            RK_PMASK: rd_mux = DATA_W'(pmask_q);
            RK_BPT:   rd_mux = DATA_W'(bpt_rd);
            RK_ALIAS: rd_mux = DATA_W'(alias_rd);
            RK_APR:   rd_mux = apr_words[apr_idx];
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/cpuif_regbank_chk.sv
// Module: cpuif_regbank_chk
// Port-level properties for cpuif_regbank, attached by bind below.
// Assumes the same parameter values as the bound instance.
module cpuif_regbank_chk #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int N_APR   = 4,
    parameter int PM_W    = 8,
    parameter bit SEC_EXT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              nonsec,
    input logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-3:0] w;
    logic              mapped;
    assign w      = addr[ADDR_W-1:2];
    assign mapped = (w == 1) || (w == 2) || (w == 7) ||
                    (int'(w) >= 52 && int'(w) < 52 + N_APR);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    p_alias_raz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && w == 7 && (!SEC_EXT || nonsec) |=> rdata == '0);
    p_unmapped_raz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !mapped |=> rdata == '0);
    p_pmask_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && w == 1 |=> rdata[DATA_W-1:PM_W] == '0);
    p_bpt_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && w == 2 |=> rdata[DATA_W-1:3] == '0);
    p_ns_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        SEC_EXT && rd_en && w == 2 && nonsec |=> rdata != '0);
endmodule

bind cpuif_regbank cpuif_regbank_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_APR(N_APR),
    .PM_W(PM_W), .SEC_EXT(SEC_EXT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .nonsec(nonsec), .rdata(rdata)
);

// File: tb/cpuif_regbank_tb.sv
// Bench: four configurations (security x revision) share one bus; a
// per-configuration model written from the requirements predicts reads.
module cpuif_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        nonsec = 1'b0;
    logic [31:0] rd_arr [4];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          m_pm  [4];
    int          m_pri [4];
    int          m_ali [4];
    logic [31:0] m_apr [4][4];

    always #10 clk = ~clk;

    generate
        for (genvar g = 0; g < 4; g++) begin : g_cfg
            cpuif_regbank #(
                .SEC_EXT ((g / 2) == 1),
                .ARCH_REV((g % 2) == 1 ? 2 : 1)
            ) u_dut (
                .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                .addr(addr), .wdata(wdata), .nonsec(nonsec),
                .rdata(rd_arr[g])
            );
        end
    endgenerate

    function automatic void mdl_reset();
        for (int i = 0; i < 4; i++) begin
            m_pm[i] = 0; m_pri[i] = 0; m_ali[i] = 1;
            for (int k = 0; k < 4; k++) m_apr[i][k] = '0;
        end
    endfunction

    function automatic void mdl_write(input logic [7:0] a, input logic [31:0] d, input bit ns);
        int w = int'(a[7:2]);
        int v = int'(d[2:0]);
        int fl = (v < 1) ? 1 : v;
        for (int i = 0; i < 4; i++) begin
            bit sec = (i / 2) == 1;
            bit r2  = (i % 2) == 1;
            if (w == 1) m_pm[i] = int'(d[7:0]);
            else if (w == 2) begin
                if (sec) begin
                    if (ns) m_ali[i] = fl; else m_pri[i] = v;
                end else begin
                    m_pri[i] = v;
                    if (r2) m_ali[i] = v;
                end
            end else if (w == 7) begin
                if (sec) begin
                    if (!ns) m_ali[i] = fl;
                end else if (r2) begin
                    m_ali[i] = fl; m_pri[i] = fl;
                end
            end else if (w >= 52 && w < 56) m_apr[i][w-52] = d;
        end
    endfunction

    function automatic logic [31:0] mdl_read(input int i, input logic [7:0] a, input bit ns);
        int w = int'(a[7:2]);
        bit sec = (i / 2) == 1;
        if (w == 1) return 32'(m_pm[i]);
        if (w == 2) return (sec && ns) ? 32'(m_ali[i]) : 32'(m_pri[i]);
        if (w == 7) return (sec && !ns) ? 32'(m_ali[i]) : 32'd0;
        if (w >= 52 && w < 56) return m_apr[i][w-52];
        return 32'd0;
    endfunction

    task automatic chk(input int i, input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cfg%0d: got %h expected %h", tag, i, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input bit ns);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; nonsec = ns;
        @(negedge clk);
        wr_en = 1'b0;
        mdl_write(a, d, ns);
    endtask

    task automatic do_read(input logic [7:0] a, input bit ns, input string tag);
        logic [31:0] exp [4];
        @(negedge clk);
        rd_en = 1'b1; addr = a; nonsec = ns;
        for (int i = 0; i < 4; i++) exp[i] = mdl_read(i, a, ns);
        @(negedge clk);
        rd_en = 1'b0;
        for (int i = 0; i < 4; i++) chk(i, rd_arr[i], exp[i], tag);
    endtask

    function automatic string tag_of(input int w);
        if (w == 7) return "R5";
        if (w == 1 || w == 2 || (w >= 52 && w < 56)) return "R1";
        return "R9";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic [31:0] hold [4];
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) chk(i, rd_arr[i], 32'd0, "R1");

        // R1 / R5 / R9: reset image of every word, both security states
        for (int w = 0; w < 64; w++)
            for (int ns = 0; ns < 2; ns++)
                do_read(8'(w * 4), ns[0], tag_of(w));

        // R2: priority mask keeps the low byte
        do_write(8'h04, 32'hFFFF_FF5A, 1'b0); do_read(8'h04, 1'b1, "R2");
        do_write(8'h05, 32'h1234_56A5, 1'b1); do_read(8'h04, 1'b0, "R2");
        do_write(8'h04, 32'h0000_0000, 1'b0); do_read(8'h04, 1'b0, "R2");

        // R3 / R4 / R5 / R6: every field value through 0x08 from both states
        for (int ns = 0; ns < 2; ns++)
            for (int v = 0; v < 8; v++) begin
                do_write(8'h08, 32'hABCD_EF08 | 32'(v), ns[0]);
                do_read(8'h08, 1'b0, "R3");
                do_read(8'h08, 1'b1, "R4");
                do_read(8'h1C, 1'b0, "R6");
                do_read(8'h1C, 1'b1, "R5");
            end

        // R6 / R7: every field value through 0x1C from both states
        for (int ns = 0; ns < 2; ns++)
            for (int v = 7; v >= 0; v--) begin
                do_write(8'h1C, 32'h5A5A_5A58 | 32'(v), ns[0]);
                do_read(8'h08, 1'b0, "R7");
                do_read(8'h08, 1'b1, "R4");
                do_read(8'h1C, 1'b0, "R6");
                do_read(8'h1C, 1'b1, "R5");
            end

        // R8: independent active-priority words
        for (int k = 0; k < 4; k++) do_write(8'(8'hD0 + k * 4), 32'hC0DE_0000 ^ (32'h1111_1111 * k), k[0]);
        do_write(8'hD6, 32'hFEED_BEEF, 1'b1);
        for (int k = 0; k < 4; k++)
            for (int ns = 0; ns < 2; ns++) do_read(8'(8'hD0 + k * 4), ns[0], "R8");
        do_read(8'hE0, 1'b0, "R9");

        // R9: writes to unmapped words leave the mapped state intact
        for (int w = 0; w < 64; w++)
            if (tag_of(w) == "R9") do_write(8'(w * 4), 32'hFFFF_FFFF, w[0]);
        foreach (m_pm[i]) ; // model unchanged by design of mdl_write
        do_read(8'h04, 1'b0, "R9");
        do_read(8'h08, 1'b0, "R9");
        do_read(8'h08, 1'b1, "R9");
        do_read(8'h1C, 1'b0, "R9");
        for (int k = 0; k < 4; k++) do_read(8'(8'hD0 + k * 4), 1'b0, "R9");

        // R10: hold while idle, and read-during-write returns the old value
        do_read(8'h04, 1'b0, "R10");
        for (int i = 0; i < 4; i++) hold[i] = rd_arr[i];
        do_write(8'h04, 32'h0000_0077, 1'b0);
        @(negedge clk);
        for (int i = 0; i < 4; i++) chk(i, rd_arr[i], hold[i], "R10");
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 8'h04; wdata = 32'h0000_0033; nonsec = 1'b0;
        for (int i = 0; i < 4; i++) hold[i] = mdl_read(i, 8'h04, 1'b0);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        mdl_write(8'h04, 32'h0000_0033, 1'b0);
        for (int i = 0; i < 4; i++) chk(i, rd_arr[i], hold[i], "R10");
        do_read(8'h04, 1'b1, "R10");

        // R1: a second reset restores the clamp floor on the alias
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        mdl_reset();
        do_read(8'h08, 1'b1, "R1");
        do_read(8'h1C, 1'b0, "R1");
        do_read(8'h04, 1'b0, "R1");

        finish_run();
    end
endmodule